// File: doc/BRIEF.md
# Abort Exception Entry Unit

This unit computes the processor state that results from taking a prefetch or data abort in a core with a secure and a non-secure world. One cycle carries an abort event together with its kind, the faulting instruction address, the current program status word, two routing configuration bits, the endianness bits of the secure and the non-secure system control registers, a high-vectors flag and the two vector base addresses. On the next clock edge the unit registers the values that the exception entry must commit: the saved status word and the link register of the target mode, the new status word and the new program counter.

External aborts can be steered to the secure monitor mode instead of abort mode. That choice changes the mode encoding, which interrupt masks are forced, where the endianness bit comes from and which vector base is used. Internal prefetch aborts are always handled in abort mode. An external imprecise data abort is only accepted while the current status word does not mask imprecise aborts. When it is masked, the event is dropped and all outputs keep their values.

Top module: `abt_entry_unit`

## Requirements
- R1: After a synchronous active-high reset, every output is zero and `ent_taken` is low.
- R2: The event kind is encoded on `ev_kind` as 0 for an internal prefetch abort, 1 for an external prefetch abort, 2 for an external precise data abort and 3 for an external imprecise data abort. Kinds 1, 2 and 3 enter monitor mode (`new_psr[4:0]` = 5'b10110, `ent_to_mon` = 1) when `cfg_ext_trap` is 1. Otherwise they enter abort mode (5'b10111, `ent_to_mon` = 0). Kind 0 always enters abort mode.
- R3: `link_addr` is the faulting address plus 4 for the prefetch kinds (0, 1) and plus 8 for the data kinds (2, 3), in either mode.
- R4: `saved_psr` equals `cur_psr` as it was in the event cycle.
- R5: In `new_psr`, bit 5 (T) and bit 24 (J) are cleared and bit 7 (IRQ mask) is set on every entry. Bits 31:25, 23:10 and 4:0 apart from the mode field are copied from `cur_psr`.
- R6: Monitor entry sets bit 6 (FIQ mask) and bit 8 (imprecise-abort mask). Abort-mode entry copies bit 6 from `cur_psr`.
- R7: On abort-mode entry, bit 8 is set when `cfg_abt_amask` is 1 and is copied from `cur_psr` when it is 0.
- R8: Bit 9 (endianness) takes `sec_endian` on monitor entry and `nsec_endian` on abort-mode entry.
- R9: The vector offset is 0xC for the prefetch kinds and 0x10 for the data kinds. On monitor entry `new_pc` is `mon_base` plus the offset. On abort-mode entry it is 0xFFFF0000 plus the offset when `hi_vec` is 1, and `nsec_base` plus the offset when it is 0.
- R10: A kind-3 event with `cur_psr[8]` = 1 is ignored: `ent_taken` stays low and every other output holds its value.
- R11: An accepted event updates all outputs at the first clock edge after the event cycle, and `ent_taken` is high for exactly that one cycle. Without an accepted event, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Abort event present this cycle |
| ev_kind | input | 2 | Abort kind (0 int prefetch, 1 ext prefetch, 2 ext precise data, 3 ext imprecise data) |
| fault_addr | input | AW | Address of the faulting instruction |
| cur_psr | input | 32 | Status word before entry |
| cfg_ext_trap | input | 1 | Route external aborts to monitor mode |
| cfg_abt_amask | input | 1 | Allow abort-mode entry to set the imprecise-abort mask |
| sec_endian | input | 1 | Endianness bit of the secure control register |
| nsec_endian | input | 1 | Endianness bit of the non-secure control register |
| hi_vec | input | 1 | High vector table selected |
| mon_base | input | AW | Monitor vector base |
| nsec_base | input | AW | Non-secure vector base |
| ent_taken | output | 1 | One-cycle pulse: entry values updated |
| ent_to_mon | output | 1 | Last entry targeted monitor mode |
| saved_psr | output | 32 | Saved status word of the target mode |
| link_addr | output | AW | Link register value of the target mode |
| new_psr | output | 32 | Status word after entry |
| new_pc | output | AW | Exception vector address |

## Verification
The bench drives an internal prefetch abort with the trap bit set to confirm it stays in abort mode; a design that routed all aborts through the trap bit would report monitor mode with the monitor vector. It sweeps the abort-mode handling of the imprecise-abort mask with both old values and both settings of the mask-write bit, which exposes a design that always sets or always clears bit 8. It also covers the 0x10 data vector offset and the +8 link offset in both modes, the high-vector base, and the swap of endianness sources. It then sends a masked imprecise data abort after a completed entry: a design that ignored the mask would pulse `ent_taken` and overwrite the held outputs.

// File: rtl/abt_pkg.sv
package abt_pkg;

  typedef enum logic [1:0] {
    ABT_PF_INT  = 2'd0,
    ABT_PF_EXT  = 2'd1,
    ABT_DA_PREC = 2'd2,
    ABT_DA_IMPR = 2'd3
  } abt_kind_e;

  localparam int PSR_W  = 32;
  localparam int BIT_T  = 5;
  localparam int BIT_F  = 6;
  localparam int BIT_I  = 7;
  localparam int BIT_A  = 8;
  localparam int BIT_E  = 9;
  localparam int BIT_J  = 24;

  localparam logic [4:0] MODE_MON = 5'b10110;
  localparam logic [4:0] MODE_ABT = 5'b10111;

  typedef struct packed {
    logic accept;
    logic to_mon;
    logic is_data;
  } abt_route_t;

endpackage

// File: rtl/abt_route.sv
module abt_route
  import abt_pkg::*;
(
  input  logic       ev_valid,
  input  logic [1:0] ev_kind,
  input  logic       cur_amask,
  input  logic       ext_trap,
  output abt_route_t route
);

  abt_kind_e kind;
  logic      is_ext;
  logic      blocked;

  always_comb begin
    kind    = abt_kind_e'(ev_kind);
    is_ext  = (kind != ABT_PF_INT);
    blocked = (kind == ABT_DA_IMPR) && cur_amask;
    route.accept  = ev_valid && !blocked;
    route.to_mon  = is_ext && ext_trap;
    route.is_data = (kind == ABT_DA_PREC) || (kind == ABT_DA_IMPR);
  end

endmodule

// File: rtl/abt_psr_gen.sv
module abt_psr_gen
  import abt_pkg::*;
(
  input  logic [PSR_W-1:0] cur_psr,
  input  logic             to_mon,
  input  logic             abt_amask,
  input  logic             sec_endian,
  input  logic             nsec_endian,
  output logic [PSR_W-1:0] psr_next
);

  always_comb begin
    psr_next        = cur_psr;
    psr_next[4:0]   = to_mon ? MODE_MON : MODE_ABT;
    psr_next[BIT_T] = 1'b0;
    psr_next[BIT_J] = 1'b0;
    psr_next[BIT_I] = 1'b1;
    psr_next[BIT_E] = to_mon ? sec_endian : nsec_endian;
    if (to_mon) begin
      psr_next[BIT_F] = 1'b1;
      psr_next[BIT_A] = 1'b1;
    end else if (abt_amask) begin
      psr_next[BIT_A] = 1'b1;
    end
  end

endmodule

// File: rtl/abt_vec_gen.sv
module abt_vec_gen #(
  parameter int             AW      = 32,
  parameter logic [AW-1:0]  HI_BASE = 32'hFFFF_0000,
  parameter logic [AW-1:0]  PF_OFS  = 32'h0000_000C,
  parameter logic [AW-1:0]  DA_OFS  = 32'h0000_0010,
  parameter logic [AW-1:0]  PF_LINK = 32'd4,
  parameter logic [AW-1:0]  DA_LINK = 32'd8
) (
  input  logic [AW-1:0] fault_addr,
  input  logic          is_data,
  input  logic          to_mon,
  input  logic          hi_vec,
  input  logic [AW-1:0] mon_base,
  input  logic [AW-1:0] nsec_base,
  output logic [AW-1:0] link_next,
  output logic [AW-1:0] pc_next
);

  logic [AW-1:0] base;
  logic [AW-1:0] ofs;

  always_comb begin
    ofs = is_data ? DA_OFS : PF_OFS;
    if (to_mon)      base = mon_base;
    else if (hi_vec) base = HI_BASE;
    else             base = nsec_base;
    pc_next   = base + ofs;
    link_next = fault_addr + (is_data ? DA_LINK : PF_LINK);
  end

endmodule

// File: rtl/abt_entry_unit.sv
module abt_entry_unit
  import abt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [AW-1:0]    fault_addr,
  input  logic [PSR_W-1:0] cur_psr,
  input  logic             cfg_ext_trap,
  input  logic             cfg_abt_amask,
  input  logic             sec_endian,
  input  logic             nsec_endian,
  input  logic             hi_vec,
  input  logic [AW-1:0]    mon_base,
  input  logic [AW-1:0]    nsec_base,
  output logic             ent_taken,
  output logic             ent_to_mon,
  output logic [PSR_W-1:0] saved_psr,
  output logic [AW-1:0]    link_addr,
  output logic [PSR_W-1:0] new_psr,
  output logic [AW-1:0]    new_pc
);

  abt_route_t       route;
  logic [PSR_W-1:0] psr_next;
  logic [AW-1:0]    link_next;
  logic [AW-1:0]    pc_next;

  abt_route u_route (
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .cur_amask (cur_psr[BIT_A]),
    .ext_trap  (cfg_ext_trap),
    .route     (route)
  );

  abt_psr_gen u_psr (
    .cur_psr     (cur_psr),
    .to_mon      (route.to_mon),
    .abt_amask   (cfg_abt_amask),
    .sec_endian  (sec_endian),
    .nsec_endian (nsec_endian),
    .psr_next    (psr_next)
  );

  abt_vec_gen #(
    .AW      (AW),
    .HI_BASE (AW'(32'hFFFF_0000)),
    .PF_OFS  (AW'(32'h0000_000C)),
    .DA_OFS  (AW'(32'h0000_0010)),
    .PF_LINK (AW'(4)),
    .DA_LINK (AW'(8))
  ) u_vec (
    .fault_addr (fault_addr),
    .is_data    (route.is_data),
    .to_mon     (route.to_mon),
    .hi_vec     (hi_vec),
    .mon_base   (mon_base),
    .nsec_base  (nsec_base),
    .link_next  (link_next),
    .pc_next    (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_taken  <= 1'b0;
      ent_to_mon <= 1'b0;
      saved_psr  <= '0;
      link_addr  <= '0;
      new_psr    <= '0;
      new_pc     <= '0;
    end else begin
      ent_taken <= route.accept;
      if (route.accept) begin
        ent_to_mon <= route.to_mon;
        saved_psr  <= cur_psr;
        link_addr  <= link_next;
        new_psr    <= psr_next;
        new_pc     <= pc_next;
      end
    end
  end

endmodule

// File: rtl/abt_entry_chk.sv
module abt_entry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_valid,
  input logic [1:0]    ev_kind,
  input logic [AW-1:0] fault_addr,
  input logic [31:0]   cur_psr,
  input logic          ent_taken,
  input logic          ent_to_mon,
  input logic [31:0]   saved_psr,
  input logic [AW-1:0] link_addr,
  input logic [31:0]   new_psr,
  input logic [AW-1:0] new_pc
);

  AST_MODE_FIELD: assert property (@(posedge clk) disable iff (rst)
    ent_taken |-> new_psr[4:0] == (ent_to_mon ? 5'b10110 : 5'b10111)); // R2

  AST_INT_PF_ABT: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 2'd0) |=> (ent_taken && !ent_to_mon)); // R2

  AST_LINK_OFS: assert property (@(posedge clk) disable iff (rst)
    ent_taken |-> link_addr == $past(fault_addr) + ($past(ev_kind[1]) ? AW'(8) : AW'(4))); // R3

  AST_SAVED_COPY: assert property (@(posedge clk) disable iff (rst)
    ent_taken |-> saved_psr == $past(cur_psr)); // R4

  AST_TJ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ent_taken |-> (!new_psr[5] && !new_psr[24] && new_psr[7])); // R5

  AST_MON_MASKS: assert property (@(posedge clk) disable iff (rst)
    (ent_taken && ent_to_mon) |-> (new_psr[6] && new_psr[8])); // R6

  AST_IMPR_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 2'd3 && cur_psr[8]) |=> !ent_taken); // R10

  AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
    !ent_taken |-> ($stable(new_pc) && $stable(new_psr) && $stable(link_addr))); // R11

endmodule

bind abt_entry_unit abt_entry_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ev_valid   (ev_valid),
  .ev_kind    (ev_kind),
  .fault_addr (fault_addr),
  .cur_psr    (cur_psr),
  .ent_taken  (ent_taken),
  .ent_to_mon (ent_to_mon),
  .saved_psr  (saved_psr),
  .link_addr  (link_addr),
  .new_psr    (new_psr),
  .new_pc     (new_pc)
);

// File: tb/test_abt_entry_unit.sv
`timescale 1ns/1ps
module test_abt_entry_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        ev_valid;
  logic [1:0]  ev_kind;
  logic [31:0] fault_addr;
  logic [31:0] cur_psr;
  logic        cfg_ext_trap;
  logic        cfg_abt_amask;
  logic        sec_endian;
  logic        nsec_endian;
  logic        hi_vec;
  logic [31:0] mon_base;
  logic [31:0] nsec_base;
  logic        ent_taken;
  logic        ent_to_mon;
  logic [31:0] saved_psr;
  logic [31:0] link_addr;
  logic [31:0] new_psr;
  logic [31:0] new_pc;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  abt_entry_unit #(.AW(32)) i_abt_entry_unit (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .fault_addr(fault_addr), .cur_psr(cur_psr), .cfg_ext_trap(cfg_ext_trap),
    .cfg_abt_amask(cfg_abt_amask), .sec_endian(sec_endian), .nsec_endian(nsec_endian),
    .hi_vec(hi_vec), .mon_base(mon_base), .nsec_base(nsec_base),
    .ent_taken(ent_taken), .ent_to_mon(ent_to_mon), .saved_psr(saved_psr),
    .link_addr(link_addr), .new_psr(new_psr), .new_pc(new_pc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one event at a falling edge; outputs are sampled one cycle later.
  task automatic fire(logic [1:0] k, logic [31:0] a, logic [31:0] p,
                      logic trap, logic aw, logic se, logic ne, logic hv);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; fault_addr = a; cur_psr = p;
    cfg_ext_trap = trap; cfg_abt_amask = aw;
    sec_endian = se; nsec_endian = ne; hi_vec = hv;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // Expected outputs derived from the requirements.
  task automatic entry(logic [1:0] k, logic [31:0] a, logic [31:0] p,
                       logic trap, logic aw, logic se, logic ne, logic hv);
    logic mon, dat;
    logic [31:0] ep, epc, ofs;
    mon = (k != 2'd0) && trap;
    dat = k[1];
    ofs = dat ? 32'h10 : 32'hC;
    ep = p;
    ep[4:0] = mon ? 5'b10110 : 5'b10111;
    ep[5] = 1'b0; ep[24] = 1'b0; ep[7] = 1'b1;
    ep[9] = mon ? se : ne;
    if (mon) begin ep[6] = 1'b1; ep[8] = 1'b1; end
    else if (aw) ep[8] = 1'b1;
    epc = mon ? mon_base + ofs : (hv ? 32'hFFFF0000 + ofs : nsec_base + ofs);
    fire(k, a, p, trap, aw, se, ne, hv);
    check("R11 taken", {31'd0, ent_taken}, 32'd1);
    check("R2 to_mon", {31'd0, ent_to_mon}, {31'd0, mon});
    check("R2 mode", {27'd0, new_psr[4:0]}, {27'd0, ep[4:0]});
    check("R3 link", link_addr, a + (dat ? 32'd8 : 32'd4));
    check("R4 saved", saved_psr, p);
    check("R5 psr", new_psr & 32'hFFFF_FE3F, ep & 32'hFFFF_FE3F);
    check("R6 fiq", {31'd0, new_psr[6]}, {31'd0, ep[6]});
    check("R7 amask", {31'd0, new_psr[8]}, {31'd0, ep[8]});
    check("R8 endian", {31'd0, new_psr[9]}, {31'd0, ep[9]});
    check("R9 vector", new_pc, epc);
    @(negedge clk);
    check("R11 pulse", {31'd0, ent_taken}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 taken", {31'd0, ent_taken}, 32'd0);
    check("R1 mon", {31'd0, ent_to_mon}, 32'd0);
    check("R1 saved", saved_psr, 32'd0);
    check("R1 link", link_addr, 32'd0);
    check("R1 psr", new_psr, 32'd0);
    check("R1 pc", new_pc, 32'd0);
  endtask

  task automatic t_prefetch();
    entry(2'd0, 32'h0000_8000, 32'h0100_0030, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R2 int stays abt
    entry(2'd1, 32'h0000_8100, 32'h0100_0030, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); // R2 R6 R8 monitor
    entry(2'd1, 32'h0000_8200, 32'h0100_0070, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); // R9 hivec
  endtask

  task automatic t_amask();
    entry(2'd0, 32'h100, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R7 stays 0
    entry(2'd0, 32'h100, 32'h0000_0150, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R7 stays 1, R6 F kept
    entry(2'd0, 32'h100, 32'h0000_0010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R7 set
  endtask

  task automatic t_data();
    entry(2'd2, 32'h4000_0000, 32'hF000_0013, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1); // R3 R9 mon data
    entry(2'd2, 32'h4000_0010, 32'hF000_0013, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R3 R9 abt data
    entry(2'd3, 32'h4000_0020, 32'h0000_0013, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // R10 unmasked accepted
  endtask

  task automatic t_masked_impr();
    logic [31:0] hp, hc, hl;
    hp = new_psr; hc = new_pc; hl = link_addr;
    fire(2'd3, 32'h5555_0000, 32'h0000_0113, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R10 taken", {31'd0, ent_taken}, 32'd0);
    check("R10 psr", new_psr, hp);
    check("R10 pc", new_pc, hc);
    check("R10 link", link_addr, hl);
  endtask

  task automatic t_hold();
    logic [31:0] hp;
    hp = new_pc;
    @(negedge clk);
    fault_addr = 32'hDEAD_BEEF; cur_psr = 32'hFFFF_FFFF; mon_base = 32'h1;
    repeat (3) @(negedge clk);
    check("R11 hold pc", new_pc, hp);
    check("R11 idle", {31'd0, ent_taken}, 32'd0);
    mon_base = 32'h0C00_0000;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ev_valid = 1'b0; ev_kind = 2'd0; fault_addr = '0; cur_psr = '0;
    cfg_ext_trap = 1'b0; cfg_abt_amask = 1'b0; sec_endian = 1'b0; nsec_endian = 1'b0;
    hi_vec = 1'b0; mon_base = 32'h0C00_0000; nsec_base = 32'h0002_0000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prefetch();
    t_amask();
    t_data();
    t_masked_impr();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule